// File: doc/BRIEF.md
# Region Memory Permission Checker

This block judges every memory access in a 32-bit address space. The space is cut into eight equal 512 MB regions, and the top address bits pick one. A requester presents an address, an access kind (instruction fetch, data read or data write), its privilege level and its security world. One cycle later the block returns an allow or deny verdict. A denied access also raises a single-cycle fault pulse and records the offending address and kind.

Each region holds read, write and execute bits for privileged code and a second set for unprivileged code. A complete copy of this table exists for the secure world and another for the non-secure world, and the requester's world picks the copy that is used. The tables are loaded through a plain configuration write port. A write is refused if it would give unprivileged code a right that privileged code lacks. A fixed 1 MB system-register window at the bottom of the top region ignores the tables: privileged code may read and write it, unprivileged code may not touch it, and nobody may fetch from it.

Requests enter on a valid/ready handshake and verdicts leave on another. A verdict stays on the output until it is taken, and no new request is accepted while an untaken verdict is waiting. The configuration port, the fault pulse and the fault record are plain signals with no handshake.

Top module: `region_perm_checker`

## Requirements
- R1: The region index is address bits [31:29], and an access uses only the table entry of that region.
- R2: A data read is allowed only when the R bit (bit 0 of a permission field) is set for the current mode, and a data write only when the W bit (bit 1) is set.
- R3: An instruction fetch (kind 2'b00) is allowed only when both the R bit and the X bit (bit 2) are set. X alone denies the fetch. Read is kind 2'b01 and write is kind 2'b10.
- R4: A privileged request (req_priv=1) is judged by the privileged field, and an unprivileged request by the unprivileged field.
- R5: A configuration write whose unprivileged field has any bit that the privileged field lacks is rejected. The stored entry is left unchanged, and cfg_err pulses high for one cycle on the cycle after the write.
- R6: Addresses 0xE0000000 to 0xE00FFFFF are allowed for privileged reads and writes, denied for every unprivileged access, and denied for every fetch, whatever the table holds.
- R7: req_secure=1 uses the secure table and 0 uses the non-secure table. cfg_secure picks the table that a write updates.
- R8: After reset every region in both tables grants R, W and X in both modes. No verdict is pending, no fault is recorded, and req_ready is high.
- R9: An accepted configuration write affects requests accepted from the next cycle on. A request accepted in the same cycle as the write is judged with the old entry.
- R10: req_ready equals !rsp_valid || rsp_ready. The verdict appears on the cycle after acceptance and holds steady while rsp_valid=1 and rsp_ready=0.
- R11: On a deny, fault_pulse is high for exactly the first cycle of that verdict. The first unrecorded fault loads fault_addr and fault_kind and sets fault_held. Later faults do not overwrite the record until fault_clr. A fault that arrives together with fault_clr is recorded.
- R12: Access kind 2'b11 is always denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 32 | Access address |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 reserved |
| req_priv | input | 1 | Requester is privileged |
| req_secure | input | 1 | Requester is in the secure world |
| rsp_valid | output | 1 | Verdict present |
| rsp_ready | input | 1 | Consumer takes the verdict |
| rsp_allow | output | 1 | 1 = allowed, 0 = denied |
| fault_pulse | output | 1 | First cycle of a deny verdict |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_secure | input | 1 | Table selected for the write |
| cfg_region | input | 3 | Region index for the write |
| cfg_priv_perm | input | 3 | Privileged {X,W,R} |
| cfg_unpriv_perm | input | 3 | Unprivileged {X,W,R} |
| cfg_err | output | 1 | Previous-cycle write was rejected |
| fault_clr | input | 1 | Clear the fault record |
| fault_held | output | 1 | A fault is recorded |
| fault_addr | output | 32 | Recorded fault address |
| fault_kind | output | 2 | Recorded fault access kind |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 3-bit region selector and a 12-bit window tag of 0xE00. With these values the region edges (0x3FFFFFFF against 0x40000000, 0x5FFFFFFF against 0x60000000) can be reached with ordinary addresses. The window edge at 0xE0100000 sits inside region 7, which separates the fixed override from the programmed table of that same region. Because there are two worlds, one write can be shown to change the non-secure table while the secure copy of the same region still grants full access.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  typedef struct packed {
    perm_t hi;   // privileged rights
    perm_t lo;   // unprivileged rights
  } entry_t;

  localparam int unsigned N_WORLDS = 2;

  localparam entry_t ENTRY_FULL = '{hi: 3'b111, lo: 3'b111};

  // Unprivileged may not hold a right privileged lacks.
  function automatic logic entry_legal(perm_t hi, perm_t lo);
    return (lo & ~hi) == 3'b000;
  endfunction

  function automatic logic perm_grants(perm_t p, acc_e k);
    case (k)
      ACC_FETCH: return p.r & p.x;
      ACC_READ:  return p.r;
      ACC_WRITE: return p.w;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rpc_perm_table.sv
module rpc_perm_table
  import rpc_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_world,
  input  logic [SEL_W-1:0] wr_region,
  input  perm_t            wr_hi,
  input  perm_t            wr_lo,
  output logic             wr_err,
  input  logic             rd_world,
  input  logic [SEL_W-1:0] rd_region,
  output entry_t           rd_entry
);

  localparam int unsigned N_REG = 1 << SEL_W;

  logic   wr_ok;
  entry_t [N_WORLDS-1:0] bank_out;

  assign wr_ok = entry_legal(wr_hi, wr_lo);

  for (genvar w = 0; w < N_WORLDS; w++) begin : g_world
    entry_t bank [N_REG];
    logic   hit_world;

    assign hit_world = wr_en && wr_ok && (wr_world == 1'(w));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int r = 0; r < N_REG; r++) bank[r] <= ENTRY_FULL;
      end else if (hit_world) begin
        bank[wr_region] <= '{hi: wr_hi, lo: wr_lo};
      end
    end

    assign bank_out[w] = bank[rd_region];

    // R5: every stored entry keeps unprivileged within privileged
    a_r5_stored_legal: assert property (@(posedge clk) disable iff (!rst_n)
      ((bank_out[w].lo & ~bank_out[w].hi) == 3'b000));
  end

  assign rd_entry = bank_out[rd_world];

  always_ff @(posedge clk) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= wr_en && !wr_ok;
  end

  // R5: an illegal write raises the error on the next cycle
  a_r5_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((wr_lo & ~wr_hi) != 3'b000)) |=> wr_err);

endmodule

// File: rtl/rpc_decide.sv
module rpc_decide
  import rpc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned WIN_TAG_W = 12,
  parameter logic [WIN_TAG_W-1:0] WIN_TAG = 12'hE00
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        kind,
  input  logic              priv,
  input  entry_t            entry,
  output logic              allow
);

  logic  in_win;
  acc_e  k;
  perm_t mode_perm;

  assign k         = acc_e'(kind);
  assign in_win    = addr[ADDR_W-1 -: WIN_TAG_W] == WIN_TAG;
  assign mode_perm = priv ? entry.hi : entry.lo;

  always_comb begin
    if (in_win) allow = priv && (k == ACC_READ || k == ACC_WRITE);
    else        allow = perm_grants(mode_perm, k);
  end

endmodule

// File: rtl/rpc_fault_log.sv
module rpc_fault_log #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [1:0]        cap_kind,
  input  logic              clr,
  output logic              held,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [1:0]        rec_kind
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= 1'b0;
      rec_addr <= '0;
      rec_kind <= '0;
    end else if (capture && (!held || clr)) begin
      held     <= 1'b1;
      rec_addr <= cap_addr;
      rec_kind <= cap_kind;
    end else if (clr) begin
      held <= 1'b0;
    end
  end

  // R11: a held record survives further faults until cleared
  a_r11_record_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !clr) |=> (held && $stable(rec_addr) && $stable(rec_kind)));

  // R11: a fault arriving with a clear is recorded
  a_r11_clr_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && clr) |=> (held && rec_addr == $past(cap_addr)));

endmodule

// File: rtl/region_perm_checker.sv
module region_perm_checker
  import rpc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned WIN_TAG_W = 12,
  parameter logic [WIN_TAG_W-1:0] WIN_TAG = 12'hE00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic              req_priv,
  input  logic              req_secure,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_allow,
  output logic              fault_pulse,
  input  logic              cfg_we,
  input  logic              cfg_secure,
  input  logic [SEL_W-1:0]  cfg_region,
  input  logic [2:0]        cfg_priv_perm,
  input  logic [2:0]        cfg_unpriv_perm,
  output logic              cfg_err,
  input  logic              fault_clr,
  output logic              fault_held,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [1:0]        fault_kind
);

  logic       fire;
  logic       verdict;
  entry_t     entry;
  logic [SEL_W-1:0] region;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign region    = req_addr[ADDR_W-1 -: SEL_W];

  rpc_perm_table #(.SEL_W(SEL_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_world  (cfg_secure),
    .wr_region (cfg_region),
    .wr_hi     (perm_t'(cfg_priv_perm)),
    .wr_lo     (perm_t'(cfg_unpriv_perm)),
    .wr_err    (cfg_err),
    .rd_world  (req_secure),
    .rd_region (region),
    .rd_entry  (entry)
  );

  rpc_decide #(
    .ADDR_W(ADDR_W), .WIN_TAG_W(WIN_TAG_W), .WIN_TAG(WIN_TAG)
  ) u_decide (
    .addr  (req_addr),
    .kind  (req_kind),
    .priv  (req_priv),
    .entry (entry),
    .allow (verdict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_allow   <= 1'b0;
      fault_pulse <= 1'b0;
    end else begin
      fault_pulse <= fire && !verdict;
      if (fire) begin
        rsp_valid <= 1'b1;
        rsp_allow <= verdict;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  rpc_fault_log #(.ADDR_W(ADDR_W)) u_log (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (fire && !verdict),
    .cap_addr (req_addr),
    .cap_kind (req_kind),
    .clr      (fault_clr),
    .held     (fault_held),
    .rec_addr (fault_addr),
    .rec_kind (fault_kind)
  );

  // R6: unprivileged access into the system window is denied
  a_r6_win_unpriv: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_addr[ADDR_W-1 -: WIN_TAG_W] == WIN_TAG && !req_priv)
      |=> !rsp_allow);

  // R6: no fetch from the system window
  a_r6_win_nofetch: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_addr[ADDR_W-1 -: WIN_TAG_W] == WIN_TAG && req_kind == 2'b00)
      |=> !rsp_allow);

  // R12: reserved kind is denied with a fault pulse
  a_r12_rsvd_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_kind == 2'b11) |=> (rsp_valid && !rsp_allow && fault_pulse));

  // R10: a stalled verdict holds steady
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_allow)));

  // R11: the fault pulse only accompanies a deny verdict
  a_r11_pulse_deny: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> (rsp_valid && !rsp_allow));

  // R11: the pulse lasts one cycle
  a_r11_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_pulse && !rsp_ready) |=> !fault_pulse);

endmodule

// File: tb/region_perm_checker_bench.sv
module region_perm_checker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_priv = 1'b0;
  logic        req_secure = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_allow;
  logic        fault_pulse;
  logic        cfg_we = 1'b0;
  logic        cfg_secure = 1'b0;
  logic [2:0]  cfg_region = '0;
  logic [2:0]  cfg_priv_perm = '0;
  logic [2:0]  cfg_unpriv_perm = '0;
  logic        cfg_err;
  logic        fault_clr = 1'b0;
  logic        fault_held;
  logic [31:0] fault_addr;
  logic [1:0]  fault_kind;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [1:0] K_F = 2'b00, K_R = 2'b01, K_W = 2'b10, K_X = 2'b11;

  always #4 clk = ~clk;

  region_perm_checker u_region_perm_checker (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_kind, .req_priv,
    .req_secure, .rsp_valid, .rsp_ready, .rsp_allow, .fault_pulse, .cfg_we,
    .cfg_secure, .cfg_region, .cfg_priv_perm, .cfg_unpriv_perm, .cfg_err,
    .fault_clr, .fault_held, .fault_addr, .fault_kind
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Issue one access; check verdict and fault pulse one cycle later.
  task automatic access(input logic [31:0] a, input logic [1:0] k,
                        input logic p, input logic s, input logic exp,
                        input string req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_kind = k; req_priv = p; req_secure = s;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid, 1'b1, req, "rsp_valid");
    chk(rsp_allow, exp, req, $sformatf("allow @%h k%0d p%0d s%0d", a, k, p, s));
    chk(fault_pulse, !exp, req, "fault_pulse");
  endtask

  task automatic cfg(input logic s, input logic [2:0] r, input logic [2:0] hi,
                     input logic [2:0] lo, input logic exp_err, input string req);
    @(negedge clk);
    cfg_we = 1'b1; cfg_secure = s; cfg_region = r;
    cfg_priv_perm = hi; cfg_unpriv_perm = lo;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_err, exp_err, req, "cfg_err");
  endtask

  task automatic clear_log();
    @(negedge clk) fault_clr = 1'b1;
    @(negedge clk) fault_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk(rsp_valid, 1'b0, "R8", "rsp_valid after reset");
    chk(fault_held, 1'b0, "R8", "fault_held after reset");
    chk(cfg_err, 1'b0, "R8", "cfg_err after reset");
    chk(req_ready, 1'b1, "R8", "req_ready after reset");
    for (int s = 0; s < 2; s++) begin
      access(32'h0000_0100, K_F, 1'b0, s[0], 1'b1, "R8");
      access(32'hA000_0040, K_W, 1'b0, s[0], 1'b1, "R8");
      access(32'h2000_0000, K_R, 1'b1, s[0], 1'b1, "R8");
    end
  endtask

  task automatic t_region_sel();
    cfg(1'b0, 3'd2, 3'b111, 3'b000, 1'b0, "R1");
    access(32'h4000_0000, K_R, 1'b0, 1'b0, 1'b0, "R1");
    access(32'h5FFF_FFFF, K_R, 1'b0, 1'b0, 1'b0, "R1");
    access(32'h3FFF_FFFC, K_R, 1'b0, 1'b0, 1'b1, "R1");
    access(32'h6000_0000, K_R, 1'b0, 1'b0, 1'b1, "R1");
    access(32'h4000_0000, K_R, 1'b1, 1'b0, 1'b1, "R4");
  endtask

  task automatic t_kinds();
    cfg(1'b0, 3'd3, 3'b001, 3'b000, 1'b0, "R2");
    access(32'h6000_0010, K_R, 1'b1, 1'b0, 1'b1, "R2");
    access(32'h6000_0010, K_W, 1'b1, 1'b0, 1'b0, "R2");
    access(32'h6000_0010, K_F, 1'b1, 1'b0, 1'b0, "R3");
    cfg(1'b0, 3'd4, 3'b110, 3'b100, 1'b0, "R3");
    access(32'h8000_0000, K_F, 1'b1, 1'b0, 1'b0, "R3");
    access(32'h8000_0000, K_W, 1'b1, 1'b0, 1'b1, "R2");
    access(32'h8000_0000, K_W, 1'b0, 1'b0, 1'b0, "R4");
    cfg(1'b0, 3'd4, 3'b101, 3'b101, 1'b0, "R3");
    access(32'h8000_0000, K_F, 1'b0, 1'b0, 1'b1, "R3");
  endtask

  task automatic t_reject();
    cfg(1'b0, 3'd3, 3'b001, 3'b011, 1'b1, "R5");
    @(negedge clk);
    chk(cfg_err, 1'b0, "R5", "cfg_err one cycle only");
    access(32'h6000_0000, K_R, 1'b0, 1'b0, 1'b0, "R5");
    access(32'h6000_0000, K_W, 1'b1, 1'b0, 1'b0, "R5");
  endtask

  task automatic t_world();
    access(32'h6000_0000, K_W, 1'b1, 1'b1, 1'b1, "R7");
    access(32'h6000_0000, K_W, 1'b1, 1'b0, 1'b0, "R7");
    cfg(1'b1, 3'd5, 3'b000, 3'b000, 1'b0, "R7");
    access(32'hA000_0000, K_R, 1'b1, 1'b1, 1'b0, "R7");
    access(32'hA000_0000, K_R, 1'b1, 1'b0, 1'b1, "R7");
  endtask

  task automatic t_window();
    access(32'hE000_0010, K_R, 1'b1, 1'b0, 1'b1, "R6");
    access(32'hE00F_FFFC, K_W, 1'b1, 1'b0, 1'b1, "R6");
    access(32'hE000_0010, K_F, 1'b1, 1'b0, 1'b0, "R6");
    access(32'hE000_0010, K_R, 1'b0, 1'b0, 1'b0, "R6");
    access(32'hE010_0000, K_R, 1'b0, 1'b0, 1'b1, "R6");
    cfg(1'b0, 3'd7, 3'b000, 3'b000, 1'b0, "R6");
    access(32'hE000_0000, K_R, 1'b1, 1'b0, 1'b1, "R6");
    access(32'hE020_0000, K_R, 1'b1, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    cfg_we = 1'b1; cfg_secure = 1'b0; cfg_region = 3'd0;
    cfg_priv_perm = 3'b000; cfg_unpriv_perm = 3'b000;
    req_valid = 1'b1; req_addr = 32'h0000_0100; req_kind = K_R;
    req_priv = 1'b1; req_secure = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk(rsp_allow, 1'b1, "R9", "same-cycle check uses old entry");
    access(32'h0000_0100, K_R, 1'b1, 1'b0, 1'b0, "R9");
  endtask

  task automatic t_rsvd();
    access(32'hC000_0000, K_X, 1'b1, 1'b1, 1'b0, "R12");
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'h2000_0000; req_kind = K_X;
    req_priv = 1'b1; req_secure = 1'b0;
    @(negedge clk);
    chk(rsp_valid, 1'b1, "R10", "verdict present");
    chk(rsp_allow, 1'b0, "R10", "verdict deny");
    chk(fault_pulse, 1'b1, "R11", "pulse first cycle");
    chk(req_ready, 1'b0, "R10", "not ready when stalled");
    req_kind = K_R;  // would be allowed, must not be accepted
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid, 1'b1, "R10", "verdict held");
    chk(rsp_allow, 1'b0, "R10", "verdict stable");
    chk(fault_pulse, 1'b0, "R11", "pulse only once");
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid, 1'b0, "R10", "verdict taken");
  endtask

  task automatic t_fault_log();
    clear_log();
    chk(fault_held, 1'b0, "R11", "held after clear");
    access(32'h0000_0200, K_W, 1'b0, 1'b0, 1'b0, "R11");
    chk(fault_held, 1'b1, "R11", "held after deny");
    chk(fault_addr, 32'h0000_0200, "R11", "fault_addr");
    chk(fault_kind, K_W, "R11", "fault_kind");
    access(32'hE000_0004, K_F, 1'b1, 1'b0, 1'b0, "R11");
    chk(fault_addr, 32'h0000_0200, "R11", "first fault kept");
    clear_log();
    chk(fault_held, 1'b0, "R11", "cleared");
    @(negedge clk);
    fault_clr = 1'b1;
    req_valid = 1'b1; req_addr = 32'h0000_0300; req_kind = K_F;
    req_priv = 1'b0; req_secure = 1'b0;
    @(negedge clk);
    fault_clr = 1'b0; req_valid = 1'b0;
    chk(fault_held, 1'b1, "R11", "fault with clear recorded");
    chk(fault_addr, 32'h0000_0300, "R11", "fault with clear addr");
    chk(fault_kind, K_F, "R11", "fault with clear kind");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_region_sel();
    t_kinds();
    t_reject();
    t_world();
    t_window();
    t_same_cycle();
    t_rsvd();
    t_backpressure();
    t_fault_log();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule